// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block produces eight pulse-width-modulated outputs from a single 16-bit counter that every channel shares. All channels therefore share one period, set by a counter start value and a modulo value. Each channel sets its own pulse width with a compare value. The counter runs in one of two ways. In edge-aligned mode it counts up and wraps. In center-aligned mode it counts up and then back down, so each pulse sits symmetrically around the low turnaround of the count.

Software sets the block up through a simple synchronous register port that uses byte offsets. The control word selects one of three clock-enable inputs, the prescaler and the counting mode. Each channel has a control word that picks PWM operation and the active level. A shared mask register forces outputs to their inactive level. A shared init register gives the level each output shows while it is not generating a waveform. A small state machine runs the counter. Its states are CS_HALT (no source selected), CS_UP and CS_DOWN. Its transitions are start (CS_HALT to CS_UP when a source is selected), wrap (CS_UP stays in CS_UP and reloads the start value after the modulo in edge mode), peak (CS_UP to CS_DOWN when the count reaches the modulo in center mode), trough (CS_DOWN to CS_UP when the count returns to the start value), realign (CS_DOWN to CS_UP when edge mode is chosen), stop (CS_UP or CS_DOWN to CS_HALT when the source field is cleared) and reload (a write to the counter offset loads the start value and enters CS_UP).

Top module: `pwm_shared_timer`

## Requirements
- R1: After reset every register reads zero, the counter reads zero and all eight outputs are low.
- R2: Control bits 4:3 choose the count source: 00 holds the counter, 01 uses the system enable, 10 uses the fixed enable and 11 uses the external enable. Only cycles where the chosen enable is high can advance the count.
- R3: Control bits 2:0 hold a prescaler code p. The counter advances once every 2^p enabled ticks. A write to the counter offset restarts the prescaler.
- R4: With control bit 5 clear (edge mode), the counter runs from the start value (offset 0x4C) up to the modulo (offset 0x08) and then reloads the start value. The period is modulo − start + 1 steps.
- R5: With control bit 5 set (center mode), the counter rises to the modulo and then falls back to the start value. The period is 2·(modulo − start) steps.
- R6: In edge mode a channel is active for compare − start steps per period. A compare equal to the start value gives 0% duty, and a compare above the modulo gives 100% duty.
- R7: In center mode a channel is active for 2·(compare − start) steps per period. A compare at or above the modulo gives 100% duty.
- R8: A channel control word (offset 0x0C + 8n) uses bit 5 to enable PWM, bit 3 for an active-high output and bit 2 for an active-low output (bit 3 wins). If bit 5 is clear, or if neither level bit is set, the output shows its init bit.
- R9: Setting bit n of the mask register (offset 0x60) forces output n to its inactive level. The inactive level is low for an active-high channel and high for an active-low channel.
- R10: While the source field is 00, each unmasked output shows bit n of the init register (offset 0x5C).
- R11: A write to the counter offset (0x04) loads the start value into the counter and begins a rising count.
- R12: Register offsets: control 0x00, counter 0x04, modulo 0x08, channel n control 0x0C + 8n, channel n compare 0x10 + 8n, start 0x4C, init 0x5C, mask 0x60. Each register reads back only its implemented bits: control bits 5:0, channel control bits 5, 3 and 2, 16-bit values, and 8-bit masks. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_sys_i | input | 1 | System-rate count enable |
| tick_fix_i | input | 1 | Fixed-rate count enable |
| tick_ext_i | input | 1 | External count enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| pwm_o | output | 8 | Registered PWM outputs |

## Verification
The bench goes after duty boundaries: compare equal to the start value, compare equal to the modulo and compare above the modulo, in both counting modes. An off-by-one at the center-mode peak or trough would show as a pulse one step short, or as a 100% channel that drops for a single step. Measurement windows span an exact number of periods, so a wrong period or wrong duty changes the high-sample and rising-edge totals. Directed cases stop the source and hold the fixed enable low to show that the count truly freezes. They also check that the prescaler restarts on a counter write, and that masking active-low channels drives them high rather than low.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam logic [7:0] OFF_CTRL    = 8'h00;
    localparam logic [7:0] OFF_COUNT   = 8'h04;
    localparam logic [7:0] OFF_MODULO  = 8'h08;
    localparam int         OFF_CH_BASE = 12;
    localparam int         CH_STRIDE   = 8;
    localparam logic [7:0] OFF_START   = 8'h4C;
    localparam logic [7:0] OFF_INIT    = 8'h5C;
    localparam logic [7:0] OFF_MASK    = 8'h60;

    typedef struct packed {
        logic       center;
        logic [1:0] src;
        logic [2:0] ps;
    } tmr_ctrl_t;

    typedef struct packed {
        logic pwm_en;
        logic hi_true;
        logic lo_true;
    } ch_ctl_t;

    typedef enum logic [1:0] {
        CS_HALT = 2'd0,
        CS_UP   = 2'd1,
        CS_DOWN = 2'd2
    } cnt_state_t;

endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [7:0]       addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic [CNT_W-1:0] count_i,
    output tmr_ctrl_t        ctrl_o,
    output logic [CNT_W-1:0] modulo_o,
    output logic [CNT_W-1:0] start_o,
    output ch_ctl_t          chctl_o [NUM_CH],
    output logic [CNT_W-1:0] cmp_o   [NUM_CH],
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] init_o,
    output logic             count_wr_o,
    output logic             ctrl_wr_o
);

    tmr_ctrl_t         ctrl_q;
    logic [CNT_W-1:0]  modulo_q;
    logic [CNT_W-1:0]  start_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] init_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata_i[31:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            modulo_q <= '0;
            start_q  <= '0;
            mask_q   <= '0;
            init_q   <= '0;
        end else if (we_i) begin
            unique case (addr_i)
                OFF_CTRL:   ctrl_q   <= wdata_i[5:0];
                OFF_MODULO: modulo_q <= wdata_i[CNT_W-1:0];
                OFF_START:  start_q  <= wdata_i[CNT_W-1:0];
                OFF_MASK:   mask_q   <= wdata_i[NUM_CH-1:0];
                OFF_INIT:   init_q   <= wdata_i[NUM_CH-1:0];
                default:    ;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chreg
        localparam logic [7:0] A_CTL = 8'(OFF_CH_BASE + CH_STRIDE * g);
        localparam logic [7:0] A_CMP = 8'(OFF_CH_BASE + CH_STRIDE * g + 4);
        ch_ctl_t          ctl_q;
        logic [CNT_W-1:0] cmp_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctl_q <= '0;
                cmp_q <= '0;
            end else if (we_i) begin
                if (addr_i == A_CTL) begin
                    ctl_q.pwm_en  <= wdata_i[5];
                    ctl_q.hi_true <= wdata_i[3];
                    ctl_q.lo_true <= wdata_i[2];
                end
                if (addr_i == A_CMP) begin
                    cmp_q <= wdata_i[CNT_W-1:0];
                end
            end
        end

        assign chctl_o[g] = ctl_q;
        assign cmp_o[g]   = cmp_q;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            OFF_CTRL:   rdata_o = 32'(ctrl_q);
            OFF_COUNT:  rdata_o = 32'(count_i);
            OFF_MODULO: rdata_o = 32'(modulo_q);
            OFF_START:  rdata_o = 32'(start_q);
            OFF_MASK:   rdata_o = 32'(mask_q);
            OFF_INIT:   rdata_o = 32'(init_q);
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (addr_i == 8'(OFF_CH_BASE + CH_STRIDE * i)) begin
                        rdata_o = {26'd0, chctl_o[i].pwm_en, 1'b0,
                                   chctl_o[i].hi_true, chctl_o[i].lo_true, 2'b00};
                    end
                    if (addr_i == 8'(OFF_CH_BASE + CH_STRIDE * i + 4)) begin
                        rdata_o = 32'(cmp_o[i]);
                    end
                end
            end
        endcase
    end

    assign ctrl_o     = ctrl_q;
    assign modulo_o   = modulo_q;
    assign start_o    = start_q;
    assign mask_o     = mask_q;
    assign init_o     = init_q;
    assign count_wr_o = we_i && (addr_i == OFF_COUNT);
    assign ctrl_wr_o  = we_i && (addr_i == OFF_CTRL);

endmodule

// File: rtl/pwm_timer_prescale.sv
module pwm_timer_prescale
    import pwm_timer_pkg::*;
#(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      src_i,
    input  logic [PS_W-1:0] ps_i,
    input  logic            tick_sys_i,
    input  logic            tick_fix_i,
    input  logic            tick_ext_i,
    input  logic            restart_i,
    input  logic            ctrl_wr_i,
    output logic            step_o
);

    localparam int DIV_W = (1 << PS_W) - 1;

    logic             tick;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        unique case (src_i)
            2'b01:   tick = tick_sys_i;
            2'b10:   tick = tick_fix_i;
            2'b11:   tick = tick_ext_i;
            default: tick = 1'b0;
        endcase
    end

    assign limit  = DIV_W'((32'd1 << ps_i) - 32'd1);
    assign step_o = tick && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            div_q <= '0;
        end else if (step_o) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= div_q + 1'b1;
        end
    end

    // R3: a divided step never repeats on the next cycle
    assert_step_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && ps_i != '0 && !restart_i && !ctrl_wr_i) |=> !step_o);

    // R2: nothing advances without a source
    assert_no_src_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i == 2'b00) |-> !step_o);

endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             center_i,
    input  logic             step_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] modulo_i,
    input  logic [CNT_W-1:0] start_i,
    output logic [CNT_W-1:0] count_o,
    output logic             rising_o
);

    cnt_state_t       st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W:0]   start_inc;

    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign start_inc = {1'b0, start_i} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CS_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        if (reload_i) begin
            cnt_n = start_i;
            st_n  = running_i ? CS_UP : CS_HALT;
        end else begin
            unique case (st_q)
                CS_HALT: begin
                    if (running_i) st_n = CS_UP;
                end
                CS_UP: begin
                    if (!running_i) begin
                        st_n = CS_HALT;
                    end else if (step_i) begin
                        if (center_i) begin
                            if (cnt_inc >= {1'b0, modulo_i}) begin
                                cnt_n = modulo_i;
                                st_n  = CS_DOWN;
                            end else begin
                                cnt_n = cnt_inc[CNT_W-1:0];
                            end
                        end else if (cnt_q >= modulo_i) begin
                            cnt_n = start_i;
                        end else begin
                            cnt_n = cnt_inc[CNT_W-1:0];
                        end
                    end
                end
                CS_DOWN: begin
                    if (!running_i) begin
                        st_n = CS_HALT;
                    end else if (!center_i) begin
                        st_n = CS_UP;
                    end else if (step_i) begin
                        if ({1'b0, cnt_q} <= start_inc) begin
                            cnt_n = start_i;
                            st_n  = CS_UP;
                        end else begin
                            cnt_n = cnt_q - 1'b1;
                        end
                    end
                end
                default: st_n = CS_HALT;
            endcase
        end
    end

    assign count_o  = cnt_q;
    assign rising_o = (st_q != CS_DOWN);

    // R4: edge mode wraps to the start value after the modulo
    assert_edge_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_UP && running_i && !center_i && step_i && !reload_i && cnt_q >= modulo_i)
        |=> cnt_q == $past(start_i));

    // R5: center mode turns upward at the start value
    assert_center_trough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CS_DOWN && running_i && center_i && step_i && !reload_i &&
         {1'b0, cnt_q} <= start_inc)
        |=> (st_q == CS_UP && cnt_q == $past(start_i)));

    // R2: counter frozen without a source
    assert_stop_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running_i && !reload_i) |=> $stable(cnt_q));

    // R11: counter write loads the start value
    assert_reload_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> cnt_q == $past(start_i));

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             rising_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  ch_ctl_t          ctl_i,
    input  logic             mask_i,
    input  logic             init_i,
    output logic             pwm_o
);

    logic pwm_mode;
    logic inactive_lvl;
    logic in_pulse;
    logic pwm_q;

    assign pwm_mode     = ctl_i.pwm_en && (ctl_i.hi_true || ctl_i.lo_true);
    assign inactive_lvl = pwm_mode ? ~ctl_i.hi_true : 1'b0;
    assign in_pulse     = rising_i ? (count_i < cmp_i) : (count_i <= cmp_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else if (mask_i) begin
            pwm_q <= inactive_lvl;
        end else if (!running_i || !pwm_mode) begin
            pwm_q <= init_i;
        end else begin
            pwm_q <= in_pulse ? ctl_i.hi_true : ~ctl_i.hi_true;
        end
    end

    assign pwm_o = pwm_q;

    // R9: a masked channel sits at its inactive level
    assert_mask_inactive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mask_i |=> pwm_o == $past((ctl_i.pwm_en && (ctl_i.hi_true || ctl_i.lo_true))
                                  ? ~ctl_i.hi_true : 1'b0));

    // R10: a halted, unmasked channel shows its init level
    assert_halt_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_i && !running_i) |=> pwm_o == $past(init_i));

endmodule

// File: rtl/pwm_shared_timer.sv
module pwm_shared_timer
    import pwm_timer_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16,
    parameter int PS_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_sys_i,
    input  logic              tick_fix_i,
    input  logic              tick_ext_i,
    input  logic              reg_we_i,
    input  logic [7:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic [NUM_CH-1:0] pwm_o
);

    tmr_ctrl_t         ctrl;
    logic [CNT_W-1:0]  modulo;
    logic [CNT_W-1:0]  start;
    ch_ctl_t           chctl [NUM_CH];
    logic [CNT_W-1:0]  cmp   [NUM_CH];
    logic [NUM_CH-1:0] mask;
    logic [NUM_CH-1:0] init;
    logic              count_wr;
    logic              ctrl_wr;
    logic              step;
    logic              running;
    logic              rising;
    logic [CNT_W-1:0]  count;

    assign running = (ctrl.src != 2'b00);

    pwm_timer_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (reg_we_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .count_i    (count),
        .ctrl_o     (ctrl),
        .modulo_o   (modulo),
        .start_o    (start),
        .chctl_o    (chctl),
        .cmp_o      (cmp),
        .mask_o     (mask),
        .init_o     (init),
        .count_wr_o (count_wr),
        .ctrl_wr_o  (ctrl_wr)
    );

    pwm_timer_prescale #(.PS_W(PS_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (ctrl.src),
        .ps_i       (ctrl.ps),
        .tick_sys_i (tick_sys_i),
        .tick_fix_i (tick_fix_i),
        .tick_ext_i (tick_ext_i),
        .restart_i  (count_wr),
        .ctrl_wr_i  (ctrl_wr),
        .step_o     (step)
    );

    pwm_timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .running_i (running),
        .center_i  (ctrl.center),
        .step_i    (step),
        .reload_i  (count_wr),
        .modulo_i  (modulo),
        .start_i   (start),
        .count_o   (count),
        .rising_o  (rising)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_timer_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .running_i (running),
            .rising_i  (rising),
            .count_i   (count),
            .cmp_i     (cmp[g]),
            .ctl_i     (chctl[g]),
            .mask_i    (mask[g]),
            .init_i    (init[g]),
            .pwm_o     (pwm_o[g])
        );
    end

endmodule

// File: tb/pwm_shared_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_shared_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_sys = 1'b0;
    logic        tick_fix = 1'b0;
    logic        tick_ext = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pwm;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #2 clk = ~clk;

    pwm_shared_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_sys_i  (tick_sys),
        .tick_fix_i  (tick_fix),
        .tick_ext_i  (tick_ext),
        .reg_we_i    (we),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .pwm_o       (pwm)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input bit center, input int src, input int ps);
        return 32'((int'(center) << 5) | (src << 3) | ps);
    endfunction

    function automatic int exp_period(input bit center, input int modv, input int st);
        return center ? 2 * (modv - st) : (modv - st + 1);
    endfunction

    function automatic int exp_active(input bit center, input int modv, input int st, input int cmp);
        if (center) return (cmp >= modv) ? 2 * (modv - st) : 2 * (cmp - st);
        return (cmp > modv) ? (modv - st + 1) : (cmp - st);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        process::self().srandom(32'd1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(pwm == 8'h00, "R1 outputs", pwm, 0);
        rd(8'h00, v); check(v == 0, "R1 ctrl", v, 0);
        rd(8'h04, v); check(v == 0, "R1 count", v, 0);
        rd(8'h08, v); check(v == 0, "R1 modulo", v, 0);
        rd(8'h60, v); check(v == 0, "R1 mask", v, 0);

        // R12 readback of implemented bits
        wr(8'h0C + 8 * 3, 32'hFF);
        rd(8'h0C + 8 * 3, v); check(v == 32'h2C, "R12 chctl", v, 32'h2C);
        wr(8'h10 + 8 * 5, 32'h1234ABCD);
        rd(8'h10 + 8 * 5, v); check(v == 32'hABCD, "R12 compare", v, 32'hABCD);
        wr(8'h60, 32'h1A5);
        rd(8'h60, v); check(v == 32'hA5, "R12 mask", v, 32'hA5);
        wr(8'h4C, 32'hFFFF0042);
        rd(8'h4C, v); check(v == 32'h42, "R12 start", v, 32'h42);
        wr(8'h00, 32'hFFC7);
        rd(8'h00, v); check(v == 32'h07, "R12 ctrl", v, 32'h07);
        wr(8'h00, 32'h0);
        wr(8'h60, 32'h0);
        wr(8'h4C, 32'h0);

        // R10 halted outputs show init bits
        wr(8'h5C, 32'hA5);
        for (int c = 0; c < 8; c++) wr(8'(12 + 8 * c), 32'h28);
        repeat (2) @(negedge clk);
        check(pwm == 8'hA5, "R10 init levels", pwm, 8'hA5);

        // R8 non-PWM channels follow init while running
        tick_sys = 1'b1;
        wr(8'h08, 32'd9);
        for (int c = 0; c < 4; c++) wr(8'(16 + 8 * c), 32'd100);
        for (int c = 4; c < 8; c++) wr(8'(12 + 8 * c), 32'h08);
        wr(8'h00, ctrl_word(0, 1, 0));
        repeat (3) @(negedge clk);
        check(pwm == 8'hAF, "R8 mixed modes", pwm, 8'hAF);

        // R9 mask forces inactive level, both polarities
        wr(8'h60, 32'h0F);
        repeat (2) @(negedge clk);
        check(pwm == 8'hA0, "R9 mask high-true", pwm, 8'hA0);
        wr(8'h0C, 32'h24);
        repeat (2) @(negedge clk);
        check(pwm == 8'hA1, "R9 mask low-true", pwm, 8'hA1);
        wr(8'h60, 32'h0);

        // R11 and R3: reload plus prescaler restart (ps = 3)
        wr(8'h08, 32'd100);
        wr(8'h4C, 32'd7);
        wr(8'h00, ctrl_word(0, 1, 3));
        wr(8'h04, 32'd0);
        rd(8'h04, v); check(v == 7, "R11 reload", v, 7);
        repeat (7) @(negedge clk);
        rd(8'h04, v); check(v == 7, "R3 prescale hold", v, 7);
        @(negedge clk);
        rd(8'h04, v); check(v == 8, "R3 prescale step", v, 8);

        // R2 fixed source with enable low, then pulsed
        wr(8'h08, 32'd1000);
        wr(8'h4C, 32'd0);
        wr(8'h00, ctrl_word(0, 2, 0));
        wr(8'h04, 32'd0);
        repeat (20) @(negedge clk);
        rd(8'h04, v); check(v == 0, "R2 fixed idle", v, 0);
        tick_fix = 1'b1;
        repeat (5) @(negedge clk);
        tick_fix = 1'b0;
        rd(8'h04, v); check(v == 5, "R2 fixed pulses", v, 5);
        wr(8'h00, ctrl_word(0, 1, 0));
        repeat (10) @(negedge clk);
        wr(8'h00, 32'h0);
        rd(8'h04, v);
        repeat (20) @(negedge clk);
        rd(8'h04, v2); check(v2 == v && v != 5, "R2 stop holds", v2, v);

        // R4-R7 random and corner periods/duties
        tick_sys = 1'b1; tick_fix = 1'b1; tick_ext = 1'b1;
        for (int t = 0; t < 24; t++) begin
            bit center;
            int st, span, modv, ps, src, per, div, win;
            int cmp [8];
            bit hi [8];
            bit msk [8];
            int hic [8];
            int rise [8];
            logic [7:0] prev;
            logic [7:0] mword;
            center = bit'(t % 2);
            st   = int'($urandom % 21);
            span = 2 + int'($urandom % 29);
            modv = st + span;
            ps   = int'($urandom % 3);
            src  = 1 + int'($urandom % 3);
            wr(8'h00, 32'h0);
            wr(8'h08, 32'(modv));
            wr(8'h4C, 32'(st));
            mword = '0;
            for (int c = 0; c < 8; c++) begin
                cmp[c] = st + int'($urandom % (span + 3));
                if (c == 0) cmp[c] = st;
                if (c == 1) cmp[c] = modv;
                if (c == 2) cmp[c] = modv + 1;
                hi[c]  = bit'($urandom % 2);
                msk[c] = (c > 2) && ($urandom % 4 == 0);
                mword[c] = msk[c];
                wr(8'(12 + 8 * c), hi[c] ? 32'h28 : 32'h24);
                wr(8'(16 + 8 * c), 32'(cmp[c]));
            end
            wr(8'h60, 32'(mword));
            wr(8'h00, ctrl_word(center, src, ps));
            wr(8'h04, 32'd0);
            per = exp_period(center, modv, st);
            div = 1 << ps;
            win = 2 * per * div;
            repeat (per * div + 4) @(negedge clk);
            for (int c = 0; c < 8; c++) begin hic[c] = 0; rise[c] = 0; end
            prev = pwm;
            for (int s = 0; s < win; s++) begin
                for (int c = 0; c < 8; c++) hic[c] += int'(prev[c]);
                @(negedge clk);
                for (int c = 0; c < 8; c++) if (!prev[c] && pwm[c]) rise[c]++;
                prev = pwm;
            end
            for (int c = 0; c < 8; c++) begin
                int act, eh, er;
                act = exp_active(center, modv, st, cmp[c]);
                if (msk[c]) begin
                    eh = hi[c] ? 0 : win;
                    er = 0;
                end else begin
                    eh = hi[c] ? 2 * act * div : win - 2 * act * div;
                    er = (act == 0 || act == per) ? 0 : 2;
                end
                if (center)
                    check(hic[c] == eh, msk[c] ? "R9 masked level" : "R7 center duty", hic[c], eh);
                else
                    check(hic[c] == eh, msk[c] ? "R9 masked level" : "R6 edge duty", hic[c], eh);
                check(rise[c] == er, center ? "R5 center period" : "R4 edge period", rise[c], er);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule